// File: doc/BRIEF.md
# Coherent Sample Readout Latch

This block keeps a held copy of two filtered acceleration channels so that a host reading them a register at a time always gets bytes that belong to the same sample. Each channel is a 14-bit two's-complement value at 0.00125 g per count. It is read as a high register that carries bits 13:4 and a low register that carries bits 3:0 right-justified with zeros above them. The filter delivers a new pair of values with a one-cycle strobe. The host issues one-cycle read strobes that select a channel and a register, and sees the selected register combinationally on `rd_data` in the same cycle.

Two mode inputs decide when the held copy may be refreshed. When `byte_free` is 0, a channel stays frozen after one of its registers is read until its other register has also been read. When `chan_free` is 0, a read of either channel freezes both channels until both have been read. For a 10-bit host that reads only high registers, `byte_free` is 1 and `chan_free` is 0. With both inputs at 1 the held copy follows every strobe. A `filt_clear` level forces every read to zero.

Each channel runs a three-state controller. ST_OPEN loads every strobe. On a freezing read it takes the transition *freeze* to ST_HELD, where strobes are dropped. When the release condition is met, including the read in that cycle, it takes the transition *release* to ST_READY. The next strobe takes the transition *reload* back to ST_OPEN, loads the newest values and clears the read flags. If a read and a strobe arrive in ST_OPEN in the same cycle, the read wins.

Top module: `coherent_sample_latch`

## Requirements
- R1: After reset, every channel/register selection reads 0 until a strobe is loaded.
- R2: With `rd_hi`=1, `rd_data` is bits 13:4 of the selected held value. With `rd_hi`=0, `rd_data[3:0]` is bits 3:0 and `rd_data[9:4]` is 0. `rd_chan`=0 selects `smp_data[13:0]` and `rd_chan`=1 selects `smp_data[27:14]`.
- R3: With `byte_free`=1 and `chan_free`=1, every strobe loads both channels whatever reads occur, and the new values are readable in the cycle after the strobe.
- R4: With `byte_free`=0 and `chan_free`=1, reading one register of a channel freezes only that channel. It is released once its other register has been read, and the other channel keeps loading meanwhile.
- R5: With `byte_free`=1 and `chan_free`=0, any read freezes both channels. Both are released once each channel has had at least one register read.
- R6: With both mode inputs at 0, the freeze lasts until all four registers have been read.
- R7: Strobes that arrive while a channel is frozen are dropped. After release, the first strobe loads the values present with it.
- R8: While `filt_clear`=1, `rd_data` is 0. Held values keep loading, and they read back once `filt_clear` returns to 0.
- R9: When a freezing read and a strobe occur in the same cycle on an open channel, the read returns the old value, the strobe is dropped and the freeze begins.
- R10: Held values are two's complement: 0x0320 (+1 g) reads high 0x032, low 0. 0x3CE0 (−1 g) reads high 0x3CE, low 0. 0x1800 (+7.68 g) reads high 0x180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_free | input | 1 | 1: no byte pairing; 0: a channel's two registers must both be read |
| chan_free | input | 1 | 1: channels independent; 0: both channels must be read |
| filt_clear | input | 1 | Filter reset level; forces reads to zero |
| smp_valid | input | 1 | New-sample strobe |
| smp_data | input | 28 | Channel 1 in bits 27:14, channel 0 in bits 13:0 |
| rd_en | input | 1 | Read strobe |
| rd_chan | input | 1 | Channel select of the read |
| rd_hi | input | 1 | 1 selects the high register, 0 the low register |
| rd_data | output | 10 | Selected register contents |

## Verification
The read that starts a freeze and a new-sample strobe can land in the same cycle. The read must return the old sample while the strobe is dropped. The bench provokes this by driving both in one cycle with both pairing modes active. It judges the result by comparing the word read in that cycle with the previously loaded value, and by reading the other channel afterwards to confirm that it too still holds the old value. A release read and a reload strobe can also coincide. This happens across the ST_HELD and ST_READY sequences, and a behavioural model compares `rd_data` with the expected value on every clock.

// File: rtl/shl_pkg.sv
package shl_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HELD  = 2'd1,
        ST_READY = 2'd2
    } hold_state_e;

endpackage

// File: rtl/shl_hold_fsm.sv
module shl_hold_fsm
    import shl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trigger,
    input  logic        release_ok,
    input  logic        strobe,
    output logic        load,
    output logic        track_en,
    output hold_state_e state
);

    hold_state_e state_q;
    hold_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        track_en = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (trigger) begin
                    // freeze: the read wins over a same-cycle strobe
                    state_d  = ST_HELD;
                    track_en = 1'b1;
                end else if (strobe) begin
                    load = 1'b1;
                end
            end
            ST_HELD: begin
                track_en = 1'b1;
                if (release_ok) begin
                    // release
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (strobe) begin
                    // reload
                    load    = 1'b1;
                    state_d = ST_OPEN;
                end
            end
            default: begin
                state_d = ST_OPEN;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/shl_read_track.sv
module shl_read_track (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_free,
    input  logic track_en,
    input  logic rd_hit,
    input  logic rd_hi,
    input  logic clear,
    output logic done_now
);

    logic hi_q, lo_q;
    logic hi_n, lo_n;

    assign hi_n     = hi_q | (track_en & rd_hit & rd_hi);
    assign lo_n     = lo_q | (track_en & rd_hit & ~rd_hi);
    assign done_now = byte_free ? (hi_n | lo_n) : (hi_n & lo_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else if (clear) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

endmodule

// File: rtl/shl_byte_view.sv
module shl_byte_view #(
    parameter int NCH = 2,
    parameter int DW  = 14,
    parameter int HIW = 10,
    parameter int CW  = 1
) (
    input  logic [NCH*DW-1:0] held_flat,
    input  logic [CW-1:0]     chan,
    input  logic              hi,
    input  logic              clear,
    output logic [HIW-1:0]    data
);

    localparam int LOW = DW - HIW;

    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan == CW'(c)) begin
                sel = held_flat[c*DW +: DW];
            end
        end
    end

    always_comb begin
        if (clear) begin
            data = '0;
        end else if (hi) begin
            data = sel[DW-1:LOW];
        end else begin
            data = {{(HIW-LOW){1'b0}}, sel[LOW-1:0]};
        end
    end

endmodule

// File: rtl/coherent_sample_latch.sv
module coherent_sample_latch
    import shl_pkg::*;
#(
    parameter int  NCH = 2,
    parameter int  DW  = 14,
    parameter int  HIW = 10,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_free,
    input  logic              chan_free,
    input  logic              filt_clear,
    input  logic              smp_valid,
    input  logic [NCH*DW-1:0] smp_data,
    input  logic              rd_en,
    input  logic [CW-1:0]     rd_chan,
    input  logic              rd_hi,
    output logic [HIW-1:0]    rd_data
);

    logic              both_free;
    logic              all_done;
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    trig;
    logic [NCH-1:0]    rel;
    logic [NCH-1:0]    load;
    logic [NCH-1:0]    track_en;
    logic [NCH-1:0]    done_now;
    hold_state_e       st     [NCH];
    logic [DW-1:0]     held_q [NCH];
    logic [NCH*DW-1:0] held_flat;

    assign both_free = byte_free & chan_free;
    assign all_done  = &done_now;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign hit[c]  = rd_en & (rd_chan == CW'(c));
        assign trig[c] = ~both_free & rd_en & (chan_free ? hit[c] : 1'b1);
        assign rel[c]  = both_free | (chan_free ? done_now[c] : all_done);

        shl_hold_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .trigger    (trig[c]),
            .release_ok (rel[c]),
            .strobe     (smp_valid),
            .load       (load[c]),
            .track_en   (track_en[c]),
            .state      (st[c])
        );

        shl_read_track u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .byte_free (byte_free),
            .track_en  (track_en[c]),
            .rd_hit    (hit[c]),
            .rd_hi     (rd_hi),
            .clear     (load[c]),
            .done_now  (done_now[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q[c] <= '0;
            end else if (load[c]) begin
                held_q[c] <= smp_data[c*DW +: DW];
            end
        end

        assign held_flat[c*DW +: DW] = held_q[c];
    end

    shl_byte_view #(
        .NCH (NCH),
        .DW  (DW),
        .HIW (HIW),
        .CW  (CW)
    ) u_view (
        .held_flat (held_flat),
        .chan      (rd_chan),
        .hi        (rd_hi),
        .clear     (filt_clear),
        .data      (rd_data)
    );

endmodule

// File: rtl/shl_checker.sv
module shl_checker
    import shl_pkg::*;
#(
    parameter int DW  = 14,
    parameter int HIW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           byte_free,
    input logic           chan_free,
    input logic           filt_clear,
    input logic           smp_valid,
    input logic [DW-1:0]  smp_ch0,
    input logic           rd_en,
    input logic           rd_hi,
    input logic [HIW-1:0] rd_data,
    input logic [DW-1:0]  held0,
    input logic [DW-1:0]  held1,
    input hold_state_e    st0,
    input hold_state_e    st1
);

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        filt_clear |-> (rd_data == '0));

    p_low_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hi) |-> (rd_data[HIW-1:DW-HIW] == '0));

    p_frozen_ch0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 == ST_HELD) |=> $stable(held0));

    p_frozen_ch1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st1 == ST_HELD) |=> $stable(held1));

    p_no_strobe_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(held0) && $stable(held1)));

    p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_free && chan_free && smp_valid && st0 == ST_OPEN) |=> (held0 == $past(smp_ch0)));

endmodule

bind coherent_sample_latch shl_checker #(
    .DW  (DW),
    .HIW (HIW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_free  (byte_free),
    .chan_free  (chan_free),
    .filt_clear (filt_clear),
    .smp_valid  (smp_valid),
    .smp_ch0    (smp_data[DW-1:0]),
    .rd_en      (rd_en),
    .rd_hi      (rd_hi),
    .rd_data    (rd_data),
    .held0      (held_q[0]),
    .held1      (held_q[1]),
    .st0        (st[0]),
    .st1        (st[1])
);

// File: tb/coherent_sample_latch_tb.sv
`timescale 1ns/1ps
module coherent_sample_latch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_free = 1'b1;
    logic        chan_free = 1'b1;
    logic        filt_clear = 1'b0;
    logic        smp_valid = 1'b0;
    logic [27:0] smp_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_chan = 1'b0;
    logic        rd_hi = 1'b0;
    logic [9:0]  rd_data;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    running = 1'b0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    coherent_sample_latch u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_free  (byte_free),
        .chan_free  (chan_free),
        .filt_clear (filt_clear),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .rd_en      (rd_en),
        .rd_chan    (rd_chan),
        .rd_hi      (rd_hi),
        .rd_data    (rd_data)
    );

    // behavioural reference: 0 open, 1 frozen, 2 released awaiting strobe
    int          m_mode [2];
    bit          m_seen_hi [2];
    bit          m_seen_lo [2];
    logic [13:0] m_val [2];
    bit          s_trig [2];
    bit          s_nh [2];
    bit          s_nl [2];
    bit          s_done [2];
    bit          s_hit, s_free, s_track, s_rel, s_take;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_mode[c] = 0; m_seen_hi[c] = 0; m_seen_lo[c] = 0; m_val[c] = '0;
            end
        end else begin
            s_free = byte_free && chan_free;
            for (int c = 0; c < 2; c++) begin
                s_hit     = rd_en && (int'(rd_chan) == c);
                s_trig[c] = !s_free && rd_en && (chan_free ? s_hit : 1'b1);
                s_track   = (m_mode[c] == 1) || (m_mode[c] == 0 && s_trig[c]);
                s_nh[c]   = m_seen_hi[c] || (s_track && s_hit && rd_hi);
                s_nl[c]   = m_seen_lo[c] || (s_track && s_hit && !rd_hi);
                s_done[c] = byte_free ? (s_nh[c] || s_nl[c]) : (s_nh[c] && s_nl[c]);
            end
            for (int c = 0; c < 2; c++) begin
                s_rel  = s_free || (chan_free ? s_done[c] : (s_done[0] && s_done[1]));
                s_take = 1'b0;
                if (m_mode[c] == 0) begin
                    if (s_trig[c]) m_mode[c] = 1;
                    else if (smp_valid) s_take = 1'b1;
                end else if (m_mode[c] == 1) begin
                    if (s_rel) m_mode[c] = 2;
                end else begin
                    if (smp_valid) begin s_take = 1'b1; m_mode[c] = 0; end
                end
                if (s_take) begin
                    m_val[c] = smp_data[c*14 +: 14];
                    m_seen_hi[c] = 0; m_seen_lo[c] = 0;
                end else begin
                    m_seen_hi[c] = s_nh[c]; m_seen_lo[c] = s_nl[c];
                end
            end
        end
    end

    function automatic logic [9:0] model_out();
        logic [13:0] v;
        v = m_val[rd_chan];
        if (filt_clear) return '0;
        if (rd_hi) return v[13:4];
        return {6'b0, v[3:0]};
    endfunction

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: rd_data got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) check(cur_tag, rd_data, model_out());
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic [13:0] v0, input logic [13:0] v1);
        smp_valid = 1'b1;
        smp_data  = {v1, v0};
        step();
        smp_valid = 1'b0;
    endtask

    task automatic rd(input bit ch, input bit hi, input logic [9:0] exp, input string tag);
        rd_en = 1'b1; rd_chan = ch; rd_hi = hi;
        @(negedge clk);
        check(tag, rd_data, exp);
        step();
        rd_en = 1'b0;
    endtask

    task automatic rd_any(input bit ch, input bit hi);
        rd_en = 1'b1; rd_chan = ch; rd_hi = hi;
        step();
        rd_en = 1'b0;
    endtask

    task automatic settle(input logic [13:0] v0, input logic [13:0] v1);
        rd_any(0, 1); rd_any(0, 0); rd_any(1, 1); rd_any(1, 0);
        strobe(v0, v1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: run got no completion, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        running = 1'b1;

        // R1: reset state
        cur_tag = "R1";
        rd(0, 1, 10'h000, "R1");
        rd(0, 0, 10'h000, "R1");
        rd(1, 1, 10'h000, "R1");
        rd(1, 0, 10'h000, "R1");

        // R10 / R2: encoding and field placement
        cur_tag = "R10";
        strobe(14'h0320, 14'h3CE0);
        rd(0, 1, 10'h032, "R10");
        rd(0, 0, 10'h000, "R10");
        rd(1, 1, 10'h3CE, "R10");
        rd(1, 0, 10'h000, "R10");
        cur_tag = "R2";
        strobe(14'h3FFF, 14'h1800);
        rd(0, 1, 10'h3FF, "R2");
        rd(0, 0, 10'h00F, "R2");
        rd(1, 1, 10'h180, "R10");
        rd(1, 0, 10'h000, "R2");

        // R3: continuous update
        cur_tag = "R3";
        strobe(14'h0101, 14'h0202);
        rd(0, 1, 10'h010, "R3");
        rd(1, 0, 10'h002, "R3");
        strobe(14'h0303, 14'h0404);
        rd(0, 0, 10'h003, "R3");
        rd(1, 1, 10'h040, "R3");

        // R4: byte pairing, channels independent
        cur_tag = "R4";
        byte_free = 1'b0; chan_free = 1'b1;
        settle(14'h0000, 14'h0000);
        strobe(14'h0123, 14'h0456);
        rd(0, 1, 10'h012, "R4");
        strobe(14'h0789, 14'h0ABC);
        rd(1, 0, 10'h00C, "R4");
        rd(0, 0, 10'h003, "R4");
        strobe(14'h0DEF, 14'h0F00);
        rd(0, 1, 10'h0DE, "R4");
        rd(1, 1, 10'h0AB, "R4");
        rd(0, 0, 10'h00F, "R4");
        strobe(14'h0001, 14'h0002);
        rd(0, 0, 10'h001, "R4");
        rd(1, 0, 10'h002, "R4");
        settle(14'h0100, 14'h0200);

        // R5: channel pairing, 10-bit reads
        cur_tag = "R5";
        byte_free = 1'b1; chan_free = 1'b0;
        settle(14'h0100, 14'h0200);
        strobe(14'h0800, 14'h0400);
        rd(0, 1, 10'h080, "R5");
        strobe(14'h0010, 14'h0020);
        rd(1, 1, 10'h040, "R5");
        rd(0, 1, 10'h080, "R7");
        strobe(14'h0030, 14'h0040);
        rd(0, 1, 10'h003, "R5");
        rd(1, 1, 10'h004, "R5");
        settle(14'h0000, 14'h0000);

        // R6: both pairings
        cur_tag = "R6";
        byte_free = 1'b0; chan_free = 1'b0;
        settle(14'h0000, 14'h0000);
        strobe(14'h1234, 14'h2345);
        rd(0, 1, 10'h123, "R6");
        rd(0, 0, 10'h004, "R6");
        rd(1, 1, 10'h234, "R6");
        strobe(14'h0111, 14'h0222);
        rd(0, 1, 10'h123, "R6");
        rd(1, 0, 10'h005, "R6");
        strobe(14'h0333, 14'h0444);
        rd(0, 1, 10'h033, "R7");
        settle(14'h0AAA, 14'h0BBB);

        // R9: freezing read and strobe in one cycle
        cur_tag = "R9";
        rd_en = 1'b1; rd_chan = 1'b0; rd_hi = 1'b1;
        smp_valid = 1'b1; smp_data = {14'h1FFF, 14'h1FFF};
        @(negedge clk);
        check("R9", rd_data, 10'h0AA);
        step();
        rd_en = 1'b0; smp_valid = 1'b0;
        rd(1, 0, 10'h00B, "R9");
        settle(14'h0000, 14'h0000);

        // R8: filter clear
        cur_tag = "R8";
        byte_free = 1'b1; chan_free = 1'b1;
        strobe(14'h0555, 14'h0666);
        filt_clear = 1'b1;
        rd(0, 1, 10'h000, "R8");
        rd(1, 0, 10'h000, "R8");
        strobe(14'h0777, 14'h0888);
        rd(1, 1, 10'h000, "R8");
        filt_clear = 1'b0;
        rd(0, 1, 10'h077, "R8");
        rd(1, 1, 10'h088, "R8");

        step();
        running = 1'b0;
        finish_run();
    end

endmodule